// File: doc/BRIEF.md
# Endpoint Buffer Window Allocator

This block keeps the bookkeeping for a shared packet buffer RAM that a USB device controller splits among its endpoints. Each endpoint has a bank count and a packet size code. From these the block derives a byte window, described by a base address and a length, that the endpoint owns inside the RAM. Software sets these values through a simple register-write port. A second write port enables and disables endpoints. The block drives every endpoint's base, length, allocated flag and enable state. It also drives a one-cycle data-lost pulse, a per-endpoint overlap flag and a RAM overflow flag.

Windows are stored, not recomputed from scratch. When an endpoint is allocated or freed, only the endpoint directly above it slides to a new address, and the data held by that endpoint is reported lost. Endpoints two or more places higher keep their addresses. A window that grows can therefore run into a window further up, and the block flags each such overlap. Software is expected to allocate endpoints in ascending order, starting from endpoint 0.

Top module: `ep_window_alloc`

## Requirements
- R1: After reset, every endpoint is unallocated and disabled. All bases and lengths read 0, and no lost, conflict or overflow flag is set.
- R2: A configuration write with a nonzero bank count (0 to 3) to endpoint x takes effect on the next clock. Endpoint x becomes allocated with length banks × (8 << size code), where the size code is 3 bits wide (0 to 7). Its base is the reported end (base + length) of endpoint x-1, or 0 when x is 0.
- R3: An unallocated endpoint reports length 0. Its base equals the end of the nearest allocated endpoint below it, or 0 if there is none.
- R4: When endpoint x is allocated and endpoint x+1 is allocated, the base of x+1 becomes the new end of x, and the lost bit of x+1 pulses.
- R5: A write of bank count 0 to an allocated endpoint x frees it. If x+1 is allocated, its base becomes x's former base and its lost bit pulses. A write of 0 to an endpoint that is already unallocated changes nothing.
- R6: Allocating or freeing endpoint x never moves the window of any allocated endpoint x+2 or higher.
- R7: The enable control sets or clears only that endpoint's enable output. Disabling an endpoint leaves its window and allocated state unchanged.
- R8: The conflict bit of endpoint i is set when i is allocated and its end exceeds the base of the nearest allocated endpoint above it.
- R9: The overflow flag is set when the end of any allocated window exceeds RAM_BYTES (4096 by default). An end exactly equal to RAM_BYTES is not an overflow.
- R10: A write naming an endpoint index of NUM_EP or higher has no effect.
- R11: A lost bit is high for exactly one cycle, in the cycle after the configuration write that caused it, and is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ep | input | EPW (3) | Endpoint index for the configuration write |
| cfg_banks | input | 2 | Bank count; 0 frees the window |
| cfg_size | input | 3 | Packet size code; size in bytes is 8 << code |
| ctl_we | input | 1 | Enable control write strobe |
| ctl_ep | input | EPW (3) | Endpoint index for the enable control |
| ctl_en | input | 1 | 1 enables the endpoint, 0 disables it |
| ep_base | output | NUM_EP × AW | Window base address for each endpoint |
| ep_len | output | NUM_EP × AW | Window length in bytes for each endpoint |
| ep_alloc | output | NUM_EP | Allocated flag for each endpoint |
| ep_en | output | NUM_EP | Enable state for each endpoint |
| ep_lost | output | NUM_EP | One-cycle pulse: the endpoint's window moved and its data is lost |
| ep_conflict | output | NUM_EP | The window overlaps the next allocated window above it |
| ram_overflow | output | 1 | Some allocated window extends past RAM_BYTES |

## Verification
A stored base that is wrong shows up on ep_base one clock after the write that set it. The same wrong value then carries into the reported base of every unallocated endpoint above it, and into any later allocation placed after it. The two most likely faults are sliding the wrong neighbour and sliding every endpoint above x. Both appear in the cycle after the write, either as a changed base on a far endpoint or as an ep_lost pulse on the wrong index. The conflict and overflow flags are combinational on the stored windows, so a wrong window or wrong comparison shows on them in the same cycle the window changes. The scenarios therefore include an end that lands exactly on the RAM limit and an end that lands exactly on the next base.

// File: rtl/ewa_pkg.sv
package ewa_pkg;
  // window size in bytes for a bank count and packet size code
  function automatic int unsigned win_bytes(input logic [1:0] banks, input logic [2:0] size_code);
    int unsigned pkt;
    pkt = 32'd8 << size_code;
    return int'(banks) * pkt;
  endfunction
endpackage

// File: rtl/ewa_view.sv
// Reported window view: unallocated endpoints collapse onto the end of the one below.
module ewa_view #(
  parameter int NUM_EP = 7,
  parameter int AW     = 16
) (
  input  logic [NUM_EP-1:0]         alloc,
  input  logic [NUM_EP-1:0][AW-1:0] sbase,
  input  logic [NUM_EP-1:0][AW-1:0] slen,
  output logic [NUM_EP-1:0][AW-1:0] rbase,
  output logic [NUM_EP-1:0][AW-1:0] rend
);
  for (genvar g = 0; g < NUM_EP; g++) begin : g_win
    logic [AW-1:0] lower;
    if (g == 0) begin : g_first
      assign lower = '0;
    end else begin : g_rest
      assign lower = rend[g-1];
    end
    assign rbase[g] = alloc[g] ? sbase[g] : lower;
    assign rend[g]  = rbase[g] + slen[g];
  end
endmodule

// File: rtl/ewa_window_regs.sv
// Stored windows and the update rules for allocate, free and enable writes.
module ewa_window_regs #(
  parameter int NUM_EP = 7,
  parameter int AW     = 16,
  parameter int EPW    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [EPW-1:0]            cfg_ep,
  input  logic [1:0]                cfg_banks,
  input  logic [2:0]                cfg_size,
  input  logic                      ctl_we,
  input  logic [EPW-1:0]            ctl_ep,
  input  logic                      ctl_en,
  input  logic [NUM_EP-1:0][AW-1:0] rend,
  output logic [NUM_EP-1:0]         alloc,
  output logic [NUM_EP-1:0][AW-1:0] sbase,
  output logic [NUM_EP-1:0][AW-1:0] slen,
  output logic [NUM_EP-1:0]         en,
  output logic [NUM_EP-1:0]         lost,
  output logic                      alloc_evt,
  output logic                      free_evt,
  output logic                      slide_evt
);
  logic [NUM_EP-1:0]         sel;
  logic [NUM_EP-1:0]         csel;
  logic [NUM_EP-1:0]         slide_sel;
  logic [NUM_EP-1:0][AW-1:0] prev_end;
  logic                      hit;
  logic                      move_evt;
  logic [AW-1:0]             new_len;
  logic [AW-1:0]             tgt_base;
  logic [AW-1:0]             cur_base;
  logic [AW-1:0]             slide_base;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_sel
    assign sel[g]  = (cfg_ep == EPW'(g));
    assign csel[g] = ctl_we && (ctl_ep == EPW'(g));
    if (g == 0) begin : g_first
      assign prev_end[g]  = '0;
      assign slide_sel[g] = 1'b0;
    end else begin : g_rest
      assign prev_end[g]  = rend[g-1];
      assign slide_sel[g] = move_evt && sel[g-1] && alloc[g];
    end
  end

  assign hit       = cfg_we && (int'(cfg_ep) < NUM_EP);
  assign alloc_evt = hit && (cfg_banks != 2'd0);
  assign free_evt  = hit && (cfg_banks == 2'd0) && |(sel & alloc);
  assign move_evt  = alloc_evt || free_evt;
  assign slide_evt = |slide_sel;
  assign new_len   = AW'(ewa_pkg::win_bytes(cfg_banks, cfg_size));

  always_comb begin
    tgt_base = '0;
    cur_base = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (sel[i]) begin
        tgt_base = prev_end[i];
        cur_base = sbase[i];
      end
    end
    slide_base = alloc_evt ? (tgt_base + new_len) : cur_base;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alloc <= '0;
      sbase <= '0;
      slen  <= '0;
      en    <= '0;
      lost  <= '0;
    end else begin
      lost <= '0;
      for (int i = 0; i < NUM_EP; i++) begin
        if (alloc_evt && sel[i]) begin
          alloc[i] <= 1'b1;
          sbase[i] <= tgt_base;
          slen[i]  <= new_len;
        end
        if (free_evt && sel[i]) begin
          alloc[i] <= 1'b0;
          slen[i]  <= '0;
        end
        if (slide_sel[i]) begin
          sbase[i] <= slide_base;
          lost[i]  <= 1'b1;
        end
        if (csel[i]) en[i] <= ctl_en;
      end
    end
  end
endmodule

// File: rtl/ewa_checks.sv
// Overlap and RAM-limit detection on the stored windows.
module ewa_checks #(
  parameter int          NUM_EP    = 7,
  parameter int          AW        = 16,
  parameter int unsigned RAM_BYTES = 4096
) (
  input  logic [NUM_EP-1:0]         alloc,
  input  logic [NUM_EP-1:0][AW-1:0] sbase,
  input  logic [NUM_EP-1:0][AW-1:0] rend,
  output logic [NUM_EP-1:0]         conflict,
  output logic                      overflow
);
  for (genvar g = 0; g < NUM_EP; g++) begin : g_ovl
    logic          found;
    logic [AW-1:0] nxt_base;
    always_comb begin
      found    = 1'b0;
      nxt_base = '0;
      for (int j = NUM_EP - 1; j > g; j--) begin
        if (alloc[j]) begin
          found    = 1'b1;
          nxt_base = sbase[j];
        end
      end
    end
    assign conflict[g] = alloc[g] && found && (rend[g] > nxt_base);
  end

  always_comb begin
    overflow = 1'b0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (alloc[i] && (32'(rend[i]) > RAM_BYTES)) overflow = 1'b1;
    end
  end
endmodule

// File: rtl/ep_window_alloc.sv
module ep_window_alloc #(
  parameter int          NUM_EP    = 7,
  parameter int          AW        = 16,
  parameter int unsigned RAM_BYTES = 4096,
  localparam int         EPW       = $clog2(NUM_EP)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [EPW-1:0]            cfg_ep,
  input  logic [1:0]                cfg_banks,
  input  logic [2:0]                cfg_size,
  input  logic                      ctl_we,
  input  logic [EPW-1:0]            ctl_ep,
  input  logic                      ctl_en,
  output logic [NUM_EP-1:0][AW-1:0] ep_base,
  output logic [NUM_EP-1:0][AW-1:0] ep_len,
  output logic [NUM_EP-1:0]         ep_alloc,
  output logic [NUM_EP-1:0]         ep_en,
  output logic [NUM_EP-1:0]         ep_lost,
  output logic [NUM_EP-1:0]         ep_conflict,
  output logic                      ram_overflow
);
  logic [NUM_EP-1:0][AW-1:0] sbase;
  logic [NUM_EP-1:0][AW-1:0] slen;
  logic [NUM_EP-1:0][AW-1:0] rend;
  logic                      alloc_evt;
  logic                      free_evt;
  logic                      slide_evt;

  ewa_window_regs #(.NUM_EP(NUM_EP), .AW(AW), .EPW(EPW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_banks(cfg_banks), .cfg_size(cfg_size),
    .ctl_we(ctl_we), .ctl_ep(ctl_ep), .ctl_en(ctl_en),
    .rend(rend), .alloc(ep_alloc), .sbase(sbase), .slen(slen),
    .en(ep_en), .lost(ep_lost),
    .alloc_evt(alloc_evt), .free_evt(free_evt), .slide_evt(slide_evt)
  );

  ewa_view #(.NUM_EP(NUM_EP), .AW(AW)) u_view (
    .alloc(ep_alloc), .sbase(sbase), .slen(slen), .rbase(ep_base), .rend(rend)
  );

  ewa_checks #(.NUM_EP(NUM_EP), .AW(AW), .RAM_BYTES(RAM_BYTES)) u_chk (
    .alloc(ep_alloc), .sbase(sbase), .rend(rend),
    .conflict(ep_conflict), .overflow(ram_overflow)
  );

  assign ep_len = slen;
endmodule

// File: rtl/ewa_sva.sv
module ewa_sva #(
  parameter int NUM_EP = 7,
  parameter int AW     = 16,
  parameter int EPW    = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cfg_we,
  input logic [EPW-1:0]            cfg_ep,
  input logic                      ctl_we,
  input logic [NUM_EP-1:0][AW-1:0] ep_base,
  input logic [NUM_EP-1:0][AW-1:0] ep_len,
  input logic [NUM_EP-1:0]         ep_alloc,
  input logic [NUM_EP-1:0]         ep_lost,
  input logic                      slide_evt
);
  AST_EP0_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ep_alloc[0] |-> ep_base[0] == '0); // R2

  AST_LOST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ep_lost)); // R4

  AST_LOST_NEEDS_SLIDE: assert property (@(posedge clk) disable iff (!rst_n)
    slide_evt |=> ep_lost != '0); // R5

  AST_CTL_KEEPS_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !cfg_we) |=> ($stable(ep_base) && $stable(ep_len) && $stable(ep_alloc))); // R7

  AST_NO_LOST_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ep_lost == '0); // R11

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    AST_FREE_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ep_alloc[g] |-> ep_len[g] == '0); // R3

    AST_FAR_WINDOW_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && ep_alloc[g] && (int'(cfg_ep) + 2 <= g)) |=> $stable(ep_base[g])); // R6

    AST_LOST_PULSE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_lost[g] && !cfg_we) |=> !ep_lost[g]); // R11
  end
endmodule

bind ep_window_alloc ewa_sva #(.NUM_EP(NUM_EP), .AW(AW), .EPW(EPW)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ep(cfg_ep), .ctl_we(ctl_we),
  .ep_base(ep_base), .ep_len(ep_len), .ep_alloc(ep_alloc), .ep_lost(ep_lost),
  .slide_evt(slide_evt)
);

// File: tb/sim_ep_window_alloc.sv
module sim_ep_window_alloc;
  localparam int N   = 7;
  localparam int AW  = 16;
  localparam int RAM = 4096;

  typedef struct packed {
    logic [N-1:0][AW-1:0] base;
    logic [N-1:0][AW-1:0] len;
    logic [N-1:0]         alloc;
    logic [N-1:0]         en;
    logic [N-1:0]         lost;
    logic [N-1:0]         conflict;
    logic                 ovf;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, ctl_we = 1'b0, ctl_en = 1'b0;
  logic [2:0] cfg_ep = '0, ctl_ep = '0, cfg_size = '0;
  logic [1:0] cfg_banks = '0;
  logic [N-1:0][AW-1:0] ep_base, ep_len;
  logic [N-1:0] ep_alloc, ep_en, ep_lost, ep_conflict;
  logic ram_overflow;

  always #5 clk = ~clk;

  ep_window_alloc u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ep(cfg_ep), .cfg_banks(cfg_banks),
    .cfg_size(cfg_size), .ctl_we(ctl_we), .ctl_ep(ctl_ep), .ctl_en(ctl_en),
    .ep_base(ep_base), .ep_len(ep_len), .ep_alloc(ep_alloc), .ep_en(ep_en),
    .ep_lost(ep_lost), .ep_conflict(ep_conflict), .ram_overflow(ram_overflow)
  );

  // bench model of the windows
  int m_base [N];
  int m_len  [N];
  bit m_alloc[N];
  bit m_en   [N];
  exp_t  q_exp[$];
  string q_tag[$];
  int vectors = 0, errors = 0;
  bit done = 1'b0;

  function automatic exp_t snapshot(input bit [N-1:0] lost);
    exp_t e;
    int cur, rb, re, j;
    int ends[N];
    e = '0;
    cur = 0;
    for (int k = 0; k < N; k++) begin
      rb = m_alloc[k] ? m_base[k] : cur;
      re = rb + m_len[k];
      ends[k] = re;
      cur = re;
      e.base[k]  = AW'(rb);
      e.len[k]   = AW'(m_len[k]);
      e.alloc[k] = m_alloc[k];
      e.en[k]    = m_en[k];
      if (m_alloc[k] && re > RAM) e.ovf = 1'b1;
    end
    for (int k = 0; k < N; k++) begin
      j = -1;
      for (int t = N - 1; t > k; t--) if (m_alloc[t]) j = t;
      if (m_alloc[k] && j >= 0 && ends[k] > m_base[j]) e.conflict[k] = 1'b1;
    end
    e.lost = lost;
    return e;
  endfunction

  function automatic int end_of(input int k);
    int cur, rb;
    cur = 0;
    for (int t = 0; t <= k; t++) begin
      rb = m_alloc[t] ? m_base[t] : cur;
      cur = rb + m_len[t];
    end
    return cur;
  endfunction

  task automatic push(input bit [N-1:0] lost, input string tag);
    q_exp.push_back(snapshot(lost));
    q_tag.push_back(tag);
  endtask

  // call at a falling edge; occupies one cycle
  task automatic cfg(input int ep, input int banks, input int sz, input string tag);
    bit [N-1:0] lost = '0;
    int nb, nl, ob;
    cfg_we = 1'b1; cfg_ep = 3'(ep); cfg_banks = 2'(banks); cfg_size = 3'(sz);
    if (ep < N) begin
      if (banks != 0) begin
        nb = (ep == 0) ? 0 : end_of(ep - 1);
        nl = banks * (8 << sz);
        m_alloc[ep] = 1'b1; m_base[ep] = nb; m_len[ep] = nl;
        if (ep + 1 < N && m_alloc[ep+1]) begin
          m_base[ep+1] = nb + nl; lost[ep+1] = 1'b1;
        end
      end else if (m_alloc[ep]) begin
        ob = m_base[ep];
        m_alloc[ep] = 1'b0; m_len[ep] = 0;
        if (ep + 1 < N && m_alloc[ep+1]) begin
          m_base[ep+1] = ob; lost[ep+1] = 1'b1;
        end
      end
    end
    push(lost, tag);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ctl(input int ep, input bit en, input string tag);
    ctl_we = 1'b1; ctl_ep = 3'(ep); ctl_en = en;
    if (ep < N) m_en[ep] = en;
    push('0, tag);
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic idle(input string tag);
    push('0, tag);
    @(negedge clk);
  endtask

  // monitor: compares one expected item per clock after the edge
  initial begin
    exp_t e;
    string tag;
    bit bad;
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) begin
        e = q_exp.pop_front();
        tag = q_tag.pop_front();
        vectors++;
        bad = 1'b0;
        if (ep_base !== e.base) begin bad = 1; $display("FAIL %s base act=%h exp=%h", tag, ep_base, e.base); end
        if (ep_len !== e.len) begin bad = 1; $display("FAIL %s len act=%h exp=%h", tag, ep_len, e.len); end
        if (ep_alloc !== e.alloc) begin bad = 1; $display("FAIL %s alloc act=%b exp=%b", tag, ep_alloc, e.alloc); end
        if (ep_en !== e.en) begin bad = 1; $display("FAIL %s en act=%b exp=%b", tag, ep_en, e.en); end
        if (ep_lost !== e.lost) begin bad = 1; $display("FAIL %s lost act=%b exp=%b", tag, ep_lost, e.lost); end
        if (ep_conflict !== e.conflict) begin bad = 1; $display("FAIL %s conflict act=%b exp=%b", tag, ep_conflict, e.conflict); end
        if (ram_overflow !== e.ovf) begin bad = 1; $display("FAIL %s overflow act=%b exp=%b", tag, ram_overflow, e.ovf); end
        if (bad) errors++;
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin
      m_base[k] = 0; m_len[k] = 0; m_alloc[k] = 0; m_en[k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    idle("R3 unallocated view");
    cfg(0, 1, 3, "R2 alloc ep0 at base 0");
    cfg(1, 2, 4, "R2 alloc ep1 after ep0");
    cfg(2, 1, 6, "R2 alloc ep2");
    for (int k = 3; k < N; k++) cfg(k, 1, 3, "R2 alloc upper endpoints");
    ctl(3, 1'b1, "R7 enable ep3");
    ctl(3, 1'b0, "R7 disable ep3 keeps window");
    cfg(3, 0, 0, "R5 free ep3 slides ep4 down");
    idle("R11 lost pulse ends");
    cfg(3, 3, 5, "R4 R6 R8 realloc ep3 larger, ep4 up, ep5 fixed");
    cfg(6, 3, 7, "R9 ep6 end exactly at limit");
    cfg(5, 1, 4, "R9 ep6 slides past limit");
    cfg(7, 2, 2, "R10 out of range write ignored");
    ctl(7, 1'b1, "R10 out of range enable ignored");
    cfg(0, 0, 0, "R5 free ep0 slides ep1 to 0");
    cfg(0, 0, 0, "R5 free of unallocated ep0 no effect");
    cfg(6, 1, 0, "R4 alloc top endpoint, no neighbour");
    cfg(1, 0, 0, "R3 R5 free ep1");
    idle("R3 view after frees");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule